// File: doc/BRIEF.md
# Lock-Aware Way Replacement Selector

This block picks the way to fill, and optionally pin, when an 8-way set-associative cache misses. Each access arrives with three things: the requesting agent's partition mask, which says which ways that agent may use; the lock bits currently stored at the missing index; and a rotating pointer for that index. From these the block returns the chosen way, the lock bits to write back, and the next value of the pointer. A locked way is never evicted while the agent still has an unlocked way it may use.

Two conflicts are resolved in hardware and reported through sticky flags. In the first, an agent asks to pin its last free way. The fill still happens, but the pin is refused, so at least one way at the index stays replaceable. In the second, every way the agent may use is already locked. The block then evicts the lowest-numbered allowed way and drops its lock. Each flag has its own interrupt enable and its own clear input. The tag store, the data store, and the storage of pointers and lock bits are outside the block.

Top module: `way_repl_sel`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first miss, `sel_vld`, `sel_way`, `lock_out`, `ptr_out`, both flags and `irq` are all zero.
- R2: A cycle with `miss_vld` high produces `sel_vld` high, for exactly one cycle, on the next clock edge. `sel_way`, `lock_out` and `ptr_out` are updated at that edge and hold their values through cycles without a miss.
- R3: A `part_mask` of all zeros allows all eight ways. The chosen way always has its bit set in the allowed set.
- R4: When at least one allowed way is unlocked, `sel_way` is the first allowed unlocked way found by scanning upward from `rr_ptr` and wrapping from way 7 to way 0. Bit i of each vector is way i. `ptr_out` is `sel_way + 1` modulo 8.
- R5: If `lock_req` is high and two or more allowed ways are unlocked, `lock_out` equals `lock_in` with the bit of the chosen way set.
- R6: If `lock_req` is high and exactly one allowed way is unlocked, that way is still chosen, `lock_out` equals `lock_in`, and `flag_lock_refuse` is set.
- R7: If every allowed way is locked, `sel_way` is the lowest allowed way and `lock_out` equals `lock_in` with that bit cleared. `flag_force_evict` is set and `ptr_out` equals `rr_ptr`. A `lock_req` in this case is not granted and does not set `flag_lock_refuse`.
- R8: If `lock_req` is low and an allowed way is unlocked, `lock_out` equals `lock_in`.
- R9: Both flags are sticky. A high `clr_lock_refuse` or `clr_force_evict` at a clock edge clears its flag. A new event at the same edge takes priority, and the flag stays set.
- R10: `irq` is `(flag_lock_refuse & ien_lock_refuse) | (flag_force_evict & ien_force_evict)` and follows changes to the enables without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_vld | input | 1 | A miss needs a way this cycle |
| lock_req | input | 1 | The miss also asks to lock the chosen way |
| part_mask | input | 8 | Ways the requester may use (zero = all) |
| lock_in | input | 8 | Lock bits stored at the missing index |
| rr_ptr | input | 3 | Rotating pointer stored for the index |
| ien_lock_refuse | input | 1 | Interrupt enable, refused-lock flag |
| ien_force_evict | input | 1 | Interrupt enable, forced-eviction flag |
| clr_lock_refuse | input | 1 | Clears the refused-lock flag |
| clr_force_evict | input | 1 | Clears the forced-eviction flag |
| sel_vld | output | 1 | Selection result valid |
| sel_way | output | 3 | Chosen way |
| lock_out | output | 8 | Lock bits to write back |
| ptr_out | output | 3 | Pointer value to write back |
| flag_lock_refuse | output | 1 | Sticky: a lock of the last free way was refused |
| flag_force_evict | output | 1 | Sticky: every allowed way was locked |
| irq | output | 1 | Enabled flags ORed together |

## Verification
Directed cases each isolate one behaviour:
- an all-zero mask, which must act as all ways allowed;
- pointers that force a wrap past way 7;
- a lock request with several free ways, then with only one;
- a fully locked partition with and without a lock request;
- a flag clear that coincides with a new event.

After these, random masks, lock vectors and pointers are applied. The lock vectors are biased toward fully locked and one-free partitions, so the refuse and force paths come up often and are compared with the plain rotating choice. Clears and enables are toggled at random. This separates a set-wins-over-clear flag from a clear-wins flag, and it checks the interrupt gating of each flag on its own.

// File: rtl/wrs_pkg.sv
package wrs_pkg;

  // Action taken for one miss.
  typedef enum logic [1:0] {
    ACT_ALLOC  = 2'd0,  // plain fill, lock bits untouched
    ACT_LOCK   = 2'd1,  // fill and pin the chosen way
    ACT_REFUSE = 2'd2,  // pin refused: last free way
    ACT_FORCE  = 2'd3   // all allowed ways pinned: evict lowest
  } repl_act_e;

  localparam int FLAG_REFUSE = 0;
  localparam int FLAG_FORCE  = 1;
  localparam int NUM_FLAGS   = 2;

endpackage

// File: rtl/wrs_mask_prep.sv
module wrs_mask_prep #(
  parameter  int NWAYS = 8,
  localparam int WAY_W = $clog2(NWAYS)
) (
  input  logic [NWAYS-1:0] part_mask,
  input  logic [NWAYS-1:0] lock_in,
  output logic [NWAYS-1:0] eff_mask,
  output logic [NWAYS-1:0] free_vec,
  output logic             any_free,
  output logic             one_free,
  output logic [WAY_W-1:0] low_way
);

  // An empty partition falls back to every way.
  always_comb begin
    eff_mask = (part_mask == '0) ? '1 : part_mask;
  end

  always_comb begin
    free_vec = eff_mask & ~lock_in;
    any_free = (free_vec != '0);
    one_free = any_free && ((free_vec & (free_vec - NWAYS'(1))) == '0);
  end

  // Lowest allowed way, the victim when everything is pinned.
  always_comb begin
    low_way = '0;
    for (int i = NWAYS - 1; i >= 0; i--) begin
      if (eff_mask[i]) low_way = WAY_W'(i);
    end
  end

endmodule

// File: rtl/wrs_rot_pick.sv
module wrs_rot_pick #(
  parameter  int NWAYS = 8,
  localparam int WAY_W = $clog2(NWAYS)
) (
  input  logic [NWAYS-1:0] free_vec,
  input  logic [WAY_W-1:0] ptr,
  output logic [WAY_W-1:0] way
);

  logic [WAY_W-1:0] idx [NWAYS];
  logic [NWAYS-1:0] rot;

  // Rotate the free vector so that position 0 is the pointer.
  for (genvar k = 0; k < NWAYS; k++) begin : g_rot
    assign idx[k] = ptr + WAY_W'(k);
    assign rot[k] = free_vec[idx[k]];
  end

  always_comb begin
    way = ptr;
    for (int k = NWAYS - 1; k >= 0; k--) begin
      if (rot[k]) way = idx[k];
    end
  end

  // R4
  always_comb begin
    if (free_vec != '0) begin
      pick_is_free_chk: assert (free_vec[way]);
    end
  end

endmodule

// File: rtl/wrs_lock_ctrl.sv
module wrs_lock_ctrl
  import wrs_pkg::*;
#(
  parameter  int NWAYS = 8,
  localparam int WAY_W = $clog2(NWAYS)
) (
  input  logic             lock_req,
  input  logic [NWAYS-1:0] lock_in,
  input  logic [WAY_W-1:0] rr_ptr,
  input  logic             any_free,
  input  logic             one_free,
  input  logic [WAY_W-1:0] pick_way,
  input  logic [WAY_W-1:0] low_way,
  output repl_act_e        act,
  output logic [WAY_W-1:0] way_nxt,
  output logic [NWAYS-1:0] lock_nxt,
  output logic [WAY_W-1:0] ptr_nxt
);

  always_comb begin
    if (!any_free)                 act = ACT_FORCE;
    else if (lock_req && one_free) act = ACT_REFUSE;
    else if (lock_req)             act = ACT_LOCK;
    else                           act = ACT_ALLOC;
  end

  always_comb begin
    way_nxt  = pick_way;
    lock_nxt = lock_in;
    ptr_nxt  = pick_way + WAY_W'(1);
    unique case (act)
      ACT_FORCE: begin
        way_nxt           = low_way;
        lock_nxt[low_way] = 1'b0;
        ptr_nxt           = rr_ptr;
      end
      ACT_LOCK:   lock_nxt[pick_way] = 1'b1;
      ACT_REFUSE: lock_nxt = lock_in;
      default:    lock_nxt = lock_in;
    endcase
  end

  // R5
  always_comb begin
    if (act == ACT_LOCK) begin
      grant_sets_bit_chk: assert (lock_nxt == (lock_in | (NWAYS'(1) << pick_way)));
    end
  end

endmodule

// File: rtl/wrs_sticky_flag.sv
module wrs_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr,
  input  logic ien,
  output logic flag,
  output logic irq_part
);

  logic flag_q;
  logic flag_d;
  logic flag_en;

  // Set has priority over a coincident clear.
  always_comb begin
    flag_en = set_evt | clr;
    flag_d  = set_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag     = flag_q;
  assign irq_part = flag_q & ien;

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q);

endmodule

// File: rtl/way_repl_sel.sv
module way_repl_sel
  import wrs_pkg::*;
#(
  parameter  int NWAYS = 8,
  localparam int WAY_W = $clog2(NWAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_vld,
  input  logic             lock_req,
  input  logic [NWAYS-1:0] part_mask,
  input  logic [NWAYS-1:0] lock_in,
  input  logic [WAY_W-1:0] rr_ptr,
  input  logic             ien_lock_refuse,
  input  logic             ien_force_evict,
  input  logic             clr_lock_refuse,
  input  logic             clr_force_evict,
  output logic             sel_vld,
  output logic [WAY_W-1:0] sel_way,
  output logic [NWAYS-1:0] lock_out,
  output logic [WAY_W-1:0] ptr_out,
  output logic             flag_lock_refuse,
  output logic             flag_force_evict,
  output logic             irq
);

  logic [NWAYS-1:0] eff_mask;
  logic [NWAYS-1:0] free_vec;
  logic             any_free;
  logic             one_free;
  logic [WAY_W-1:0] low_way;
  logic [WAY_W-1:0] pick_way;
  repl_act_e        act;
  logic [WAY_W-1:0] way_nxt;
  logic [NWAYS-1:0] lock_nxt;
  logic [WAY_W-1:0] ptr_nxt;

  wrs_mask_prep #(.NWAYS(NWAYS)) u_mask (
    .part_mask (part_mask),
    .lock_in   (lock_in),
    .eff_mask  (eff_mask),
    .free_vec  (free_vec),
    .any_free  (any_free),
    .one_free  (one_free),
    .low_way   (low_way)
  );

  wrs_rot_pick #(.NWAYS(NWAYS)) u_pick (
    .free_vec (free_vec),
    .ptr      (rr_ptr),
    .way      (pick_way)
  );

  wrs_lock_ctrl #(.NWAYS(NWAYS)) u_lock (
    .lock_req (lock_req),
    .lock_in  (lock_in),
    .rr_ptr   (rr_ptr),
    .any_free (any_free),
    .one_free (one_free),
    .pick_way (pick_way),
    .low_way  (low_way),
    .act      (act),
    .way_nxt  (way_nxt),
    .lock_nxt (lock_nxt),
    .ptr_nxt  (ptr_nxt)
  );

  // Result registers, loaded only on a miss.
  logic             vld_q;
  logic [WAY_W-1:0] way_q;
  logic [NWAYS-1:0] lock_q;
  logic [WAY_W-1:0] ptr_q;
  logic             res_en;

  assign res_en = miss_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= miss_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      way_q  <= '0;
      lock_q <= '0;
      ptr_q  <= '0;
    end else if (res_en) begin
      way_q  <= way_nxt;
      lock_q <= lock_nxt;
      ptr_q  <= ptr_nxt;
    end
  end

  assign sel_vld  = vld_q;
  assign sel_way  = way_q;
  assign lock_out = lock_q;
  assign ptr_out  = ptr_q;

  // Error flags.
  logic [NUM_FLAGS-1:0] flag_evt;
  logic [NUM_FLAGS-1:0] flag_clr;
  logic [NUM_FLAGS-1:0] flag_ien;
  logic [NUM_FLAGS-1:0] flag_val;
  logic [NUM_FLAGS-1:0] flag_irq;

  always_comb begin
    flag_evt[FLAG_REFUSE] = miss_vld && (act == ACT_REFUSE);
    flag_evt[FLAG_FORCE]  = miss_vld && (act == ACT_FORCE);
    flag_clr[FLAG_REFUSE] = clr_lock_refuse;
    flag_clr[FLAG_FORCE]  = clr_force_evict;
    flag_ien[FLAG_REFUSE] = ien_lock_refuse;
    flag_ien[FLAG_FORCE]  = ien_force_evict;
  end

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    wrs_sticky_flag u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_evt  (flag_evt[f]),
      .clr      (flag_clr[f]),
      .ien      (flag_ien[f]),
      .flag     (flag_val[f]),
      .irq_part (flag_irq[f])
    );
  end

  assign flag_lock_refuse = flag_val[FLAG_REFUSE];
  assign flag_force_evict = flag_val[FLAG_FORCE];
  assign irq              = |flag_irq;

  // R2
  vld_follows_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_vld |-> $past(miss_vld));

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_vld |=> ($stable(sel_way) && $stable(lock_out) && $stable(ptr_out)));

  // R3
  pick_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_vld |-> ((($past(eff_mask) >> sel_way) & NWAYS'(1)) != '0));

  // R4
  free_never_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_vld && any_free) |=> ((($past(lock_in) >> sel_way) & NWAYS'(1)) == '0));

  // R6
  refuse_keeps_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_vld && lock_req && one_free) |=> (lock_out == $past(lock_in) && flag_lock_refuse));

  // R7
  force_clears_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_vld && !any_free) |=>
      ((((lock_out >> sel_way) & NWAYS'(1)) == '0) && flag_force_evict && ptr_out == $past(rr_ptr)));

endmodule

// File: tb/way_repl_sel_bench.sv
module way_repl_sel_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       miss_vld, lock_req;
  logic [7:0] part_mask, lock_in;
  logic [2:0] rr_ptr;
  logic       ien_lock_refuse, ien_force_evict, clr_lock_refuse, clr_force_evict;
  logic       sel_vld;
  logic [2:0] sel_way;
  logic [7:0] lock_out;
  logic [2:0] ptr_out;
  logic       flag_lock_refuse, flag_force_evict, irq;

  always #4 clk = ~clk;

  way_repl_sel u_way_repl_sel (
    .clk(clk), .rst_n(rst_n), .miss_vld(miss_vld), .lock_req(lock_req),
    .part_mask(part_mask), .lock_in(lock_in), .rr_ptr(rr_ptr),
    .ien_lock_refuse(ien_lock_refuse), .ien_force_evict(ien_force_evict),
    .clr_lock_refuse(clr_lock_refuse), .clr_force_evict(clr_force_evict),
    .sel_vld(sel_vld), .sel_way(sel_way), .lock_out(lock_out), .ptr_out(ptr_out),
    .flag_lock_refuse(flag_lock_refuse), .flag_force_evict(flag_force_evict), .irq(irq)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  // Expected state.
  logic [2:0] e_way;
  logic [7:0] e_lock;
  logic [2:0] e_ptr;
  logic       e_fref, e_ffrc;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Reference selection per the requirements.
  function automatic void model(input logic [7:0] pm, input logic [7:0] li, input logic [2:0] rp,
                                input logic lr, output logic [2:0] w, output logic [7:0] lk,
                                output logic [2:0] p, output logic rf, output logic fc);
    logic [7:0] em, fr;
    int nfree;
    em = (pm == 8'h00) ? 8'hFF : pm;
    fr = em & ~li;
    nfree = 0;
    for (int i = 0; i < 8; i++) if (fr[i]) nfree++;
    rf = 0; fc = 0; lk = li; w = 0; p = rp;
    if (nfree == 0) begin
      for (int i = 7; i >= 0; i--) if (em[i]) w = 3'(i);
      lk[w] = 1'b0;
      fc = 1;
    end else begin
      for (int k = 7; k >= 0; k--) if (fr[3'(rp + 3'(k))]) w = 3'(rp + 3'(k));
      p = w + 3'd1;
      if (lr) begin
        if (nfree == 1) rf = 1;
        else lk[w] = 1'b1;
      end
    end
  endfunction

  task automatic step(input logic m, input logic lr, input logic [7:0] pm, input logic [7:0] li,
                      input logic [2:0] rp, input logic cr, input logic cf, input string wtag);
    logic [2:0] w, p;
    logic [7:0] lk;
    logic rf, fc;
    string ltag;
    miss_vld = m; lock_req = lr; part_mask = pm; lock_in = li; rr_ptr = rp;
    clr_lock_refuse = cr; clr_force_evict = cf;
    model(pm, li, rp, lr, w, lk, p, rf, fc);
    if (!m) begin rf = 0; fc = 0; end
    e_fref = rf | (e_fref & ~cr);
    e_ffrc = fc | (e_ffrc & ~cf);
    if (m) begin e_way = w; e_lock = lk; e_ptr = p; end
    @(posedge clk);
    @(negedge clk);
    miss_vld = 1'b0; clr_lock_refuse = 1'b0; clr_force_evict = 1'b0;
    ltag = fc ? "R7" : (lr ? (rf ? "R6" : "R5") : "R8");
    check("R2", "sel_vld", sel_vld, m);
    check(m ? (wtag != "" ? wtag : (fc ? "R7" : "R4")) : "R2", "sel_way", sel_way, e_way);
    check(m ? ltag : "R2", "lock_out", lock_out, e_lock);
    check(m ? (fc ? "R7" : "R4") : "R2", "ptr_out", ptr_out, e_ptr);
    check(rf ? "R6" : "R9", "flag_lock_refuse", flag_lock_refuse, e_fref);
    check(fc ? "R7" : "R9", "flag_force_evict", flag_force_evict, e_ffrc);
    check("R10", "irq", irq, (e_fref & ien_lock_refuse) | (e_ffrc & ien_force_evict));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_2024));
    rst_n = 1'b0; miss_vld = 0; lock_req = 0; part_mask = 0; lock_in = 0; rr_ptr = 0;
    ien_lock_refuse = 0; ien_force_evict = 0; clr_lock_refuse = 0; clr_force_evict = 0;
    e_way = 0; e_lock = 0; e_ptr = 0; e_fref = 0; e_ffrc = 0;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", "sel_vld", sel_vld, 0);
    check("R1", "flags", {flag_lock_refuse, flag_force_evict, irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "sel_way", sel_way, 0);
    check("R1", "lock_out", lock_out, 0);
    check("R1", "ptr_out", ptr_out, 0);
    check("R1", "flags after release", {flag_lock_refuse, flag_force_evict, irq}, 0);

    // R3: empty mask means all ways
    step(1, 0, 8'h00, 8'h00, 3'd5, 0, 0, "R3");
    step(1, 0, 8'h00, 8'hE0, 3'd5, 0, 0, "R3");
    // R4: wrap past way 7
    step(1, 0, 8'h03, 8'h00, 3'd7, 0, 0, "R4");
    step(1, 0, 8'h81, 8'h00, 3'd2, 0, 0, "R4");
    // R2: idle cycle holds
    step(0, 0, 8'hFF, 8'hFF, 3'd1, 0, 0, "");
    // R5: grant with several free
    step(1, 1, 8'h0F, 8'h01, 3'd0, 0, 0, "");
    // R6: refuse last free way
    ien_lock_refuse = 1;
    step(1, 1, 8'h03, 8'h02, 3'd1, 0, 0, "");
    // R7: all allowed locked, with a lock request
    step(1, 1, 8'h0C, 8'hFF, 3'd6, 0, 0, "");
    // R9: clear together with a new event keeps the flag
    step(1, 0, 8'h30, 8'h30, 3'd0, 0, 1, "");
    step(0, 0, 8'h00, 8'h00, 3'd0, 0, 1, "");
    step(0, 0, 8'h00, 8'h00, 3'd0, 1, 0, "");
    // R10: enables gate irq without a clock edge
    step(1, 0, 8'h01, 8'h01, 3'd0, 0, 0, "");
    ien_force_evict = 1; #1;
    check("R10", "irq enable live", irq, 1);
    ien_force_evict = 0; #1;
    check("R10", "irq enable off", irq, 0);
    @(negedge clk);

    for (int it = 0; it < 600; it++) begin
      logic [7:0] pm, li;
      logic [3:0] sel;
      pm  = 8'($urandom);
      if (($urandom & 7) == 0) pm = 8'h00;
      sel = 4'($urandom);
      li  = 8'($urandom);
      if (sel < 3) li = (pm == 0) ? 8'hFF : (pm | li);
      else if (sel < 6) li = ((pm == 0) ? 8'hFF : pm) & ~(8'h01 << ($urandom & 7)) | (li & ~pm);
      if (($urandom & 15) == 0) begin
        ien_lock_refuse = 1'($urandom);
        ien_force_evict = 1'($urandom);
      end
      step(1'(($urandom & 7) != 0), 1'($urandom), pm, li, 3'($urandom),
           1'(($urandom & 15) == 0), 1'(($urandom & 15) == 0), "");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule